// File: doc/BRIEF.md
# Disk File Address Counter

This block keeps the 16-bit file address that a moving-head disk controller uses to locate a record. The address has four fields, and their bit positions are fixed because the drive and the rest of the controller decode them:

| Field | Bits | Meaning |
|---|---|---|
| sector | 4..0 | sector within the track |
| disk select | 5 | 1 = fixed platter, 0 = removable platter |
| surface | 6 | 0 = top, 1 = bottom |
| cylinder | 15..7 | cylinder number |

Software loads a start address, and the block checks it against the geometry of the drive. A valid address is stored, and the block sends a one-cycle seek strobe with the target cylinder. An address that is out of range raises an address error and leaves the stored value unchanged.

During a transfer over several sectors, the controller pulses an advance input once per completed sector, and the block steps the address in disk geometry order. The sector counts up to 28 and then wraps. On that wrap the surface flips. When the surface goes from bottom back to top, the cylinder advances. The disk-select bit is never touched by a step. A model input picks the last legal cylinder: 405 for the large drive and 202 for the small one. A step that would go past that cylinder raises the address error, which ends the transfer.

Top module: `disk_addr_ctr`

## Requirements
- R1: While reset is high and on the first cycle after it, `addr_o` is 0, and `strobe_o`, `seek_cyl_o` and `addr_err_o` are all 0.
- R2: A load whose sector field is 0..28 and whose cylinder field is within the model limit is valid. One cycle later, `addr_o` holds the loaded word unchanged and `addr_err_o` is 0.
- R3: A valid load makes `strobe_o` high for exactly the next cycle. From that cycle on, `seek_cyl_o` holds the loaded cylinder (bits 15..7) until the next valid load.
- R4: A load with a sector field of 29, 30 or 31 sets `addr_err_o`. It leaves `addr_o` unchanged and gives no strobe.
- R5: The last legal cylinder is 405 when `big_model_i` = 1 and 202 when it is 0. A load with a cylinder above that limit acts like R4.
- R6: An advance on a sector from 0 to 27 adds one to the sector and leaves the other fields unchanged.
- R7: An advance on sector 28 with surface 0 (top) gives sector 0 and surface 1 (bottom), with the same cylinder.
- R8: An advance on sector 28 with surface 1 gives sector 0, surface 0 and cylinder + 1.
- R9: An advance never changes bit 5 (disk select). Only a valid load changes it.
- R10: An advance that needs cylinder + 1 while the cylinder is already at or above the model limit sets `addr_err_o` and leaves `addr_o` unchanged. While `addr_err_o` is 1, advances are ignored. Only a valid load clears the error.
- R11: When a load and an advance arrive in the same cycle, the load is carried out and the advance is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| load_i | input | 1 | one-cycle request to load `load_addr_i` |
| load_addr_i | input | 16 | file address to load |
| advance_i | input | 1 | one-cycle pulse at the end of each completed sector |
| big_model_i | input | 1 | 1 = large drive (last cylinder 405), 0 = small drive (202) |
| addr_o | output | 16 | current file address |
| strobe_o | output | 1 | one-cycle seek strobe after a valid load |
| seek_cyl_o | output | 9 | cylinder sent to the drive with the strobe |
| addr_err_o | output | 1 | address error, kept until the next valid load |

## Verification
A wrong sector field or a wrong wrap decision shows on `addr_o` one cycle after the advance that caused it. Because the error then carries forward, every later compare against the reference model also disagrees. A wrong limit or a missed overflow shows on `addr_err_o` in the cycle after the offending load or step. It also shows at once as a missing or extra strobe. Crossing both surfaces and cylinder wraps with the disk bit set to 1 catches any step logic that touches bit 5.

// File: rtl/disk_addr_pkg.sv
package disk_addr_pkg;
  parameter int SECT_W         = 5;
  parameter int CYL_W          = 9;
  parameter int SECTORS        = 29;
  parameter int CYL_LAST_BIG   = 405;
  parameter int CYL_LAST_SMALL = 202;
  localparam int ADDR_W   = SECT_W + 2 + CYL_W;
  localparam int DISK_BIT = SECT_W;
  localparam int SURF_BIT = SECT_W + 1;
  localparam int CYL_LSB  = SECT_W + 2;
endpackage

// File: rtl/dac_load_check.sv
module dac_load_check #(
  parameter int SECT_W         = 5,
  parameter int CYL_W          = 9,
  parameter int SECTORS        = 29,
  parameter int CYL_LAST_BIG   = 405,
  parameter int CYL_LAST_SMALL = 202
) (
  input  logic [SECT_W-1:0] sec_i,
  input  logic [CYL_W-1:0]  cyl_i,
  input  logic              big_i,
  output logic              ok_o
);
  localparam logic [SECT_W-1:0] LAST_SEC  = SECT_W'(SECTORS - 1);
  localparam logic [CYL_W-1:0]  LIM_BIG   = CYL_W'(CYL_LAST_BIG);
  localparam logic [CYL_W-1:0]  LIM_SMALL = CYL_W'(CYL_LAST_SMALL);

  logic [CYL_W-1:0] lim;

  always_comb begin
    lim  = big_i ? LIM_BIG : LIM_SMALL;
    ok_o = (sec_i <= LAST_SEC) && (cyl_i <= lim);
  end
endmodule

// File: rtl/dac_step.sv
module dac_step #(
  parameter int SECT_W         = 5,
  parameter int CYL_W          = 9,
  parameter int SECTORS        = 29,
  parameter int CYL_LAST_BIG   = 405,
  parameter int CYL_LAST_SMALL = 202,
  localparam int ADDR_W        = SECT_W + 2 + CYL_W
) (
  input  logic [ADDR_W-1:0] cur_i,
  input  logic              big_i,
  output logic [ADDR_W-1:0] nxt_o,
  output logic              ovf_o
);
  localparam int SURF_BIT = SECT_W + 1;
  localparam int CYL_LSB  = SECT_W + 2;
  localparam logic [SECT_W-1:0] LAST_SEC  = SECT_W'(SECTORS - 1);
  localparam logic [CYL_W-1:0]  LIM_BIG   = CYL_W'(CYL_LAST_BIG);
  localparam logic [CYL_W-1:0]  LIM_SMALL = CYL_W'(CYL_LAST_SMALL);

  logic [SECT_W-1:0] sec;
  logic [CYL_W-1:0]  cyl, lim;
  logic              surf;

  always_comb begin
    sec   = cur_i[SECT_W-1:0];
    surf  = cur_i[SURF_BIT];
    cyl   = cur_i[ADDR_W-1:CYL_LSB];
    lim   = big_i ? LIM_BIG : LIM_SMALL;
    nxt_o = cur_i;
    ovf_o = 1'b0;
    if (sec < LAST_SEC) begin
      nxt_o[SECT_W-1:0] = sec + 1'b1;
    end else begin
      nxt_o[SECT_W-1:0] = '0;
      if (!surf) begin
        nxt_o[SURF_BIT] = 1'b1;
      end else begin
        nxt_o[SURF_BIT] = 1'b0;
        if (cyl >= lim) ovf_o = 1'b1;
        else nxt_o[ADDR_W-1:CYL_LSB] = cyl + 1'b1;
      end
    end
  end
endmodule

// File: rtl/disk_addr_ctr.sv
module disk_addr_ctr
  import disk_addr_pkg::*;
#(
  parameter int P_SECT_W    = SECT_W,
  parameter int P_CYL_W     = CYL_W,
  parameter int P_SECTORS   = SECTORS,
  parameter int P_LAST_BIG  = CYL_LAST_BIG,
  parameter int P_LAST_SMALL = CYL_LAST_SMALL,
  localparam int AW         = P_SECT_W + 2 + P_CYL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [AW-1:0]     load_addr_i,
  input  logic              advance_i,
  input  logic              big_model_i,
  output logic [AW-1:0]     addr_o,
  output logic              strobe_o,
  output logic [P_CYL_W-1:0] seek_cyl_o,
  output logic              addr_err_o
);
  localparam int C_LSB = P_SECT_W + 2;

  logic          load_ok;
  logic          step_ovf;
  logic [AW-1:0] step_addr;

  dac_load_check #(
    .SECT_W(P_SECT_W), .CYL_W(P_CYL_W), .SECTORS(P_SECTORS),
    .CYL_LAST_BIG(P_LAST_BIG), .CYL_LAST_SMALL(P_LAST_SMALL)
  ) u_check (
    .sec_i (load_addr_i[P_SECT_W-1:0]),
    .cyl_i (load_addr_i[AW-1:C_LSB]),
    .big_i (big_model_i),
    .ok_o  (load_ok)
  );

  dac_step #(
    .SECT_W(P_SECT_W), .CYL_W(P_CYL_W), .SECTORS(P_SECTORS),
    .CYL_LAST_BIG(P_LAST_BIG), .CYL_LAST_SMALL(P_LAST_SMALL)
  ) u_step (
    .cur_i (addr_o),
    .big_i (big_model_i),
    .nxt_o (step_addr),
    .ovf_o (step_ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o     <= '0;
      strobe_o   <= 1'b0;
      seek_cyl_o <= '0;
      addr_err_o <= 1'b0;
    end else begin
      strobe_o <= 1'b0;
      if (load_i) begin
        if (load_ok) begin
          addr_o     <= load_addr_i;
          strobe_o   <= 1'b1;
          seek_cyl_o <= load_addr_i[AW-1:C_LSB];
          addr_err_o <= 1'b0;
        end else begin
          addr_err_o <= 1'b1;
        end
      end else if (advance_i && !addr_err_o) begin
        if (step_ovf) addr_err_o <= 1'b1;
        else addr_o <= step_addr;
      end
    end
  end
endmodule

// File: rtl/disk_addr_ctr_chk.sv
module disk_addr_ctr_chk #(
  parameter int AW = 16,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst,
  input logic          load_i,
  input logic          advance_i,
  input logic [AW-1:0] addr_o,
  input logic          strobe_o,
  input logic [CW-1:0] seek_cyl_o,
  input logic          addr_err_o
);
  AST_SECTOR_LEGAL: assert property (@(posedge clk) disable iff (rst)
    addr_o[4:0] <= 5'd28);                                             // R2
  AST_STROBE_CYL: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> (seek_cyl_o == addr_o[AW-1:AW-CW]) && !addr_err_o);     // R3
  AST_STROBE_FROM_LOAD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> !strobe_o);                                            // R3
  AST_SECTOR_STEP: assert property (@(posedge clk) disable iff (rst)
    (advance_i && !load_i && !addr_err_o && addr_o[4:0] < 5'd28)
      |=> addr_o[4:0] == $past(addr_o[4:0]) + 5'd1);                   // R6
  AST_DISK_KEEP: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> addr_o[5] == $past(addr_o[5]));                        // R9
  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (addr_err_o && !load_i) |=> $stable(addr_o) && addr_err_o);        // R10
endmodule

bind disk_addr_ctr disk_addr_ctr_chk #(.AW(AW), .CW(P_CYL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_i     (load_i),
  .advance_i  (advance_i),
  .addr_o     (addr_o),
  .strobe_o   (strobe_o),
  .seek_cyl_o (seek_cyl_o),
  .addr_err_o (addr_err_o)
);

// File: tb/sim_disk_addr_ctr.sv
`timescale 1ns/1ps
module sim_disk_addr_ctr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_i = 1'b0;
  logic [15:0] load_addr_i = '0;
  logic        advance_i = 1'b0;
  logic        big_model_i = 1'b1;
  logic [15:0] addr_o;
  logic        strobe_o;
  logic [8:0]  seek_cyl_o;
  logic        addr_err_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference state
  int m_sec = 0, m_surf = 0, m_disk = 0, m_cyl = 0;
  int m_err = 0, m_strobe = 0, m_seek = 0;

  always #5 clk = ~clk;

  disk_addr_ctr u0 (
    .clk(clk), .rst(rst), .load_i(load_i), .load_addr_i(load_addr_i),
    .advance_i(advance_i), .big_model_i(big_model_i), .addr_o(addr_o),
    .strobe_o(strobe_o), .seek_cyl_o(seek_cyl_o), .addr_err_o(addr_err_o)
  );

  function automatic int pack(int cyl, int surf, int disk, int sec);
    return cyl * 128 + surf * 64 + disk * 32 + sec;
  endfunction

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    int lim, s, c;
    lim = big_model_i ? 405 : 202;
    if (rst) begin
      m_sec = 0; m_surf = 0; m_disk = 0; m_cyl = 0;
      m_err = 0; m_strobe = 0; m_seek = 0;
    end else begin
      m_strobe = 0;
      if (load_i) begin
        s = load_addr_i % 32;
        c = load_addr_i / 128;
        if (s <= 28 && c <= lim) begin
          m_sec = s; m_disk = (load_addr_i / 32) % 2;
          m_surf = (load_addr_i / 64) % 2; m_cyl = c;
          m_strobe = 1; m_seek = c; m_err = 0;
        end else m_err = 1;
      end else if (advance_i && m_err == 0) begin
        if (m_sec < 28) m_sec = m_sec + 1;
        else if (m_surf == 0) begin m_sec = 0; m_surf = 1; end
        else if (m_cyl >= lim) m_err = 1;
        else begin m_sec = 0; m_surf = 0; m_cyl = m_cyl + 1; end
      end
    end
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare against the reference on every falling edge
  always @(negedge clk) begin
    cycles++;
    check(cur_req, "addr", int'(addr_o), pack(m_cyl, m_surf, m_disk, m_sec));
    check(cur_req, "strobe", int'(strobe_o), m_strobe);
    check(cur_req, "seek_cyl", int'(seek_cyl_o), m_seek);
    check(cur_req, "err", int'(addr_err_o), m_err);
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic do_load(int a);
    @(negedge clk); load_addr_i = 16'(a); load_i = 1'b1;
    @(negedge clk); load_i = 1'b0;
  endtask

  task automatic do_adv(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); advance_i = 1'b1;
      @(negedge clk); advance_i = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check("R1", "reset addr", int'(addr_o), 0);
    check("R1", "reset err", int'(addr_err_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "post-reset strobe", int'(strobe_o), 0);

    cur_req = "R2";
    do_load(pack(100, 0, 1, 5));
    check("R2", "loaded word", int'(addr_o), 12837);
    cur_req = "R3";
    @(negedge clk); load_addr_i = 16'(pack(7, 1, 0, 3)); load_i = 1'b1;
    @(negedge clk); load_i = 1'b0;
    check("R3", "strobe after load", int'(strobe_o), 1);
    check("R3", "seek cylinder", int'(seek_cyl_o), 7);
    @(negedge clk);
    check("R3", "strobe one cycle", int'(strobe_o), 0);

    cur_req = "R4";
    do_load(pack(50, 0, 0, 29));
    check("R4", "err on sector 29", int'(addr_err_o), 1);
    check("R4", "addr kept", int'(addr_o), pack(7, 1, 0, 3));
    check("R4", "no strobe", int'(strobe_o), 0);
    do_load(pack(50, 1, 1, 31));

    cur_req = "R5";
    big_model_i = 1'b0;
    do_load(pack(203, 0, 0, 0));
    check("R5", "small limit 203", int'(addr_err_o), 1);
    do_load(pack(202, 1, 0, 28));
    check("R5", "small limit 202", int'(addr_err_o), 0);
    big_model_i = 1'b1;
    do_load(pack(406, 0, 0, 0));
    check("R5", "big limit 406", int'(addr_err_o), 1);
    do_load(pack(405, 0, 0, 0));
    check("R5", "big limit 405", int'(addr_err_o), 0);

    cur_req = "R6";
    do_load(pack(10, 0, 0, 0));
    do_adv(5);
    check("R6", "sector +5", int'(addr_o), pack(10, 0, 0, 5));

    cur_req = "R7";
    do_load(pack(20, 0, 1, 27));
    do_adv(2);
    check("R7", "top to bottom", int'(addr_o), pack(20, 1, 1, 0));
    cur_req = "R8";
    do_adv(28);
    do_adv(1);
    check("R8", "next cylinder", int'(addr_o), pack(21, 0, 1, 0));
    cur_req = "R9";
    do_adv(70);
    check("R9", "disk bit kept", int'(addr_o[5]), 1);

    cur_req = "R10";
    big_model_i = 1'b0;
    do_load(pack(202, 1, 1, 27));
    do_adv(1);
    do_adv(1);
    check("R10", "overflow err", int'(addr_err_o), 1);
    check("R10", "addr held", int'(addr_o), pack(202, 1, 1, 28));
    do_adv(3);
    check("R10", "advance ignored", int'(addr_o), pack(202, 1, 1, 28));
    do_load(pack(0, 0, 0, 0));
    check("R10", "cleared by load", int'(addr_err_o), 0);
    big_model_i = 1'b1;

    cur_req = "R11";
    do_load(pack(30, 0, 0, 4));
    @(negedge clk); load_addr_i = 16'(pack(60, 1, 1, 9));
    load_i = 1'b1; advance_i = 1'b1;
    @(negedge clk); load_i = 1'b0; advance_i = 1'b0;
    check("R11", "load wins", int'(addr_o), pack(60, 1, 1, 9));
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule